// File: doc/BRIEF.md
# Serial Management Slave (Two-Wire MDC/MDIO Device Side)

This block is the device end of a two-wire management bus. A station manager supplies the management clock and sends frames on a single shared data line. The block sees that line through three signals: a sampled input, an output value and an output enable. It waits for a run of ones as a synchronising preamble, then decodes the start pattern, the operation, a 5-bit device address and a 5-bit register address. When the frame is addressed to this device, the block turns it into a simple register-file access: a one-cycle read request with the register index, or a one-cycle write strobe with index and 16-bit data.

The device address is formed from a 3-bit strap input. The two upper address bits are always zero. Address zero has no special meaning: it is only the address of a device whose strap is zero. Read data comes back on the line after a two-bit turnaround, most significant bit first. Frames for other devices are followed silently to their end, and the line is never driven during them. Any malformed frame is abandoned. In that case decoding resumes only after a new full preamble.

Top module: `mgmt_serial_slave`

## Requirements
- R1: While reset is asserted, md_oe, rd_req and wr_en are all 0.
- R2: A frame is recognised only after at least 32 consecutive ones sampled on the line, followed by a 0 and then a 1. A 0 that arrives before 32 ones have been counted restarts the count, and the frame that follows it is ignored.
- R3: The two operation bits are 10 for a read and 01 for a write. The values 00 and 11 abandon the frame. After that, no frame is decoded until a new run of 32 ones has been seen.
- R4: The device responds only when the 5-bit device address, sent MSB first, has its two upper bits equal to 00 and its lower three bits equal to strap_addr. Otherwise it produces no rd_req, no wr_en and no drive.
- R5: Device address 00000 is not a broadcast address. With a nonzero strap, a frame sent to address 0 is ignored. With strap 0, that frame is handled normally.
- R6: On a matching read, rd_req is high for exactly one cycle, starting just after the rising edge that samples the last register-address bit. reg_addr carries the 5-bit index, MSB first. rd_data must be valid at the following rising edge.
- R7: On a matching read, md_oe stays 0 during the first turnaround bit. md_oe is then 1 with md_out 0 for the second turnaround bit. Then 16 data bits are driven MSB first, each changing just after a rising edge. md_oe is high for exactly 17 cycles in total.
- R8: On a write, the turnaround bits must be 1 then 0. Any other pair abandons the frame and no wr_en is produced.
- R9: On a matching write, wr_en is high for exactly one cycle, in the cycle after the rising edge that samples the last data bit. wr_data holds the 16 data bits (first bit sent is bit 15), and reg_addr holds the index.
- R10: After the data field, md_oe returns to 0. The next frame is decoded after a fresh run of 32 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the station; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_addr | input | 3 | Low three bits of this device's address |
| md_in | input | 1 | Sampled value of the shared data line |
| md_out | output | 1 | Value driven onto the data line when enabled |
| md_oe | output | 1 | Output enable for the data line |
| reg_addr | output | 5 | Register index of the current access |
| rd_req | output | 1 | One-cycle read request |
| rd_data | input | 16 | Register value for reg_addr, valid one cycle after rd_req |
| wr_en | output | 1 | One-cycle write strobe |
| wr_data | output | 16 | Write value, valid with wr_en |

## Verification
Some properties are checked on every cycle by assertions in the design. rd_req and wr_en never last longer than one cycle. The line is still undriven in the cycle of a read request, and the device drives a 0 in the cycle after it. Every driven burst lasts exactly 17 cycles. A 0 received during preamble hunting always leaves the hunter unarmed. Other behaviours can only be shown by the bench's frame scenarios: comparison of the strap against the address, rejection of broadcast-style address zero, recovery after a malformed frame only on a new preamble, and the bit order of read and write data.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SOF,
    ST_OPC,
    ST_DEV,
    ST_REG,
    ST_TURN,
    ST_DATA
  } mgmt_state_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mgmt_preamble_det.sv
module mgmt_preamble_det #(
  parameter int PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_in,
  output logic armed
);

  localparam int CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(PRE_LEN);

  logic [CW-1:0] ones_q, ones_d;

  always_comb begin
    if (!en)
      ones_d = '0;
    else if (bit_in)
      ones_d = (ones_q == FULL) ? ones_q : ones_q + 1'b1;
    else
      ones_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end

  assign armed = (ones_q == FULL);

  // R2: a zero seen while hunting always leaves the hunter unarmed
  a_r2_zero_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bit_in) |=> !armed);

endmodule

// File: rtl/mgmt_addr_match.sv
module mgmt_addr_match #(
  parameter int DEV_AW  = 5,
  parameter int STRAP_W = 3
) (
  input  logic [DEV_AW-1:0]  dev_addr,
  input  logic [STRAP_W-1:0] strap,
  output logic               hit
);

  generate
    if (DEV_AW > STRAP_W) begin : g_upper_zero
      assign hit = (dev_addr[DEV_AW-1:STRAP_W] == '0) &&
                   (dev_addr[STRAP_W-1:0] == strap);
    end else begin : g_full_strap
      logic [STRAP_W-1:0] wide_addr;
      assign wide_addr = STRAP_W'(dev_addr);
      assign hit = (wide_addr == strap);
    end
  endgenerate

endmodule

// File: rtl/mgmt_tx_shift.sv
module mgmt_tx_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic          msb
);

  logic [DW-1:0] q, d;

  always_comb begin
    d = q;
    if (load)
      d = din;
    else if (shift)
      d = {q[DW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign msb = q[DW-1];

endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave
  import mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DEV_AW  = 5,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 16,
  parameter int STRAP_W = 3
) (
  input  logic               mdc,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               md_in,
  output logic               md_out,
  output logic               md_oe,
  output logic [REG_AW-1:0]  reg_addr,
  output logic               rd_req,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               wr_en,
  output logic [DATA_W-1:0]  wr_data
);

  localparam int MAXF = (DATA_W > DEV_AW) ?
                        ((DATA_W > REG_AW) ? DATA_W : REG_AW) :
                        ((DEV_AW > REG_AW) ? DEV_AW : REG_AW);
  localparam int SHW  = MAXF;
  localparam int CNTW = $clog2(MAXF);
  localparam logic [CNTW-1:0] DEV_LAST  = CNTW'(DEV_AW - 1);
  localparam logic [CNTW-1:0] REG_LAST  = CNTW'(REG_AW - 1);
  localparam logic [CNTW-1:0] DATA_LAST = CNTW'(DATA_W - 1);
  localparam int DRV_LEN = DATA_W + 1;
  localparam int DCW     = $clog2(DRV_LEN + 1) + 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  mgmt_state_e        st_q, st_d;
  logic [CNTW-1:0]    cnt_q, cnt_d;
  logic [SHW-2:0]     sh_q;
  logic [SHW-1:0]     sh_d;
  logic               is_rd_q, is_rd_d;
  logic               match_q, match_d;
  logic [REG_AW-1:0]  reg_q, reg_d;
  logic               rd_req_q, rd_req_d;
  logic               wr_en_q, wr_en_d;
  logic [DATA_W-1:0]  wr_data_q, wr_data_d;
  logic               oe_q, oe_d;
  logic               out_q, out_d;
  logic               tx_load, tx_shift, tx_msb;
  logic               pre_armed, dev_hit;

  mgmt_preamble_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk   (mdc),
    .rst_n (rst_sync_n),
    .en    (st_q == ST_HUNT),
    .bit_in(md_in),
    .armed (pre_armed)
  );

  mgmt_addr_match #(.DEV_AW(DEV_AW), .STRAP_W(STRAP_W)) u_match (
    .dev_addr(sh_d[DEV_AW-1:0]),
    .strap   (strap_addr),
    .hit     (dev_hit)
  );

  mgmt_tx_shift #(.DW(DATA_W)) u_tx (
    .clk  (mdc),
    .rst_n(rst_sync_n),
    .load (tx_load),
    .shift(tx_shift),
    .din  (rd_data),
    .msb  (tx_msb)
  );

  assign sh_d = {sh_q, md_in};

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    is_rd_d   = is_rd_q;
    match_d   = match_q;
    reg_d     = reg_q;
    rd_req_d  = 1'b0;
    wr_en_d   = 1'b0;
    wr_data_d = wr_data_q;
    oe_d      = oe_q;
    out_d     = out_q;
    tx_load   = 1'b0;
    tx_shift  = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (pre_armed && !md_in) st_d = ST_SOF;
      end
      ST_SOF: begin
        cnt_d = '0;
        st_d  = md_in ? ST_OPC : ST_HUNT;
      end
      ST_OPC: begin
        if (cnt_q == '0) begin
          cnt_d = 1'b1;
        end else begin
          cnt_d = '0;
          if ({sh_q[0], md_in} == OPC_READ) begin
            is_rd_d = 1'b1;
            st_d    = ST_DEV;
          end else if ({sh_q[0], md_in} == OPC_WRITE) begin
            is_rd_d = 1'b0;
            st_d    = ST_DEV;
          end else begin
            st_d    = ST_HUNT;
          end
        end
      end
      ST_DEV: begin
        if (cnt_q == DEV_LAST) begin
          match_d = dev_hit;
          cnt_d   = '0;
          st_d    = ST_REG;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_REG: begin
        if (cnt_q == REG_LAST) begin
          reg_d    = sh_d[REG_AW-1:0];
          rd_req_d = match_q && is_rd_q;
          cnt_d    = '0;
          st_d     = ST_TURN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt_q == '0) begin
          if (!is_rd_q && !md_in) begin
            st_d = ST_HUNT;
          end else begin
            cnt_d = 1'b1;
            if (is_rd_q && match_q) begin
              oe_d    = 1'b1;
              out_d   = 1'b0;
              tx_load = 1'b1;
            end
          end
        end else begin
          if (!is_rd_q && md_in) begin
            st_d = ST_HUNT;
          end else begin
            cnt_d = '0;
            st_d  = ST_DATA;
            if (is_rd_q && match_q) begin
              out_d    = tx_msb;
              tx_shift = 1'b1;
            end
          end
        end
      end
      ST_DATA: begin
        if (cnt_q == DATA_LAST) begin
          st_d  = ST_HUNT;
          cnt_d = '0;
          oe_d  = 1'b0;
          out_d = 1'b0;
          if (!is_rd_q && match_q) begin
            wr_en_d   = 1'b1;
            wr_data_d = sh_d[DATA_W-1:0];
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
          if (is_rd_q && match_q) begin
            out_d    = tx_msb;
            tx_shift = 1'b1;
          end
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge mdc or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q      <= ST_HUNT;
      cnt_q     <= '0;
      sh_q      <= '0;
      is_rd_q   <= 1'b0;
      match_q   <= 1'b0;
      reg_q     <= '0;
      rd_req_q  <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
      oe_q      <= 1'b0;
      out_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d[SHW-2:0];
      is_rd_q   <= is_rd_d;
      match_q   <= match_d;
      reg_q     <= reg_d;
      rd_req_q  <= rd_req_d;
      wr_en_q   <= wr_en_d;
      wr_data_q <= wr_data_d;
      oe_q      <= oe_d;
      out_q     <= out_d;
    end
  end

  assign md_out   = out_q;
  assign md_oe    = oe_q;
  assign reg_addr = reg_q;
  assign rd_req   = rd_req_q;
  assign wr_en    = wr_en_q;
  assign wr_data  = wr_data_q;

  // ---------------- assertions ----------------
  logic [DCW-1:0] drv_cnt;
  always_ff @(posedge mdc or negedge rst_sync_n) begin
    if (!rst_sync_n)  drv_cnt <= '0;
    else if (md_oe)   drv_cnt <= drv_cnt + 1'b1;
    else              drv_cnt <= '0;
  end

  // R6: read request is a single-cycle pulse
  a_r6_rd_pulse: assert property (@(posedge mdc) disable iff (!rst_sync_n)
    rd_req |=> !rd_req);

  // R7: first turnaround bit undriven, second driven low
  a_r7_turn_float: assert property (@(posedge mdc) disable iff (!rst_sync_n)
    rd_req |-> !md_oe);
  a_r7_turn_zero: assert property (@(posedge mdc) disable iff (!rst_sync_n)
    rd_req |=> (md_oe && !md_out));

  // R7/R10: every driven burst lasts turnaround bit plus data field
  a_r7_drive_len: assert property (@(posedge mdc) disable iff (!rst_sync_n)
    $fell(md_oe) |-> (drv_cnt == DCW'(DRV_LEN)));

  // R9: write strobe is a single-cycle pulse, never while driving
  a_r9_wr_pulse: assert property (@(posedge mdc) disable iff (!rst_sync_n)
    wr_en |=> !wr_en);
  a_r9_wr_quiet: assert property (@(posedge mdc) disable iff (!rst_sync_n)
    wr_en |-> !md_oe);

endmodule

// File: tb/mgmt_serial_slave_bench.sv
module mgmt_serial_slave_bench;

  localparam int CLK_PERIOD = 10;

  logic        mdc = 1'b0;
  logic        rst_n;
  logic [2:0]  strap;
  logic        st_oe, st_drv;
  wire         md_line;
  logic        md_out, md_oe, rd_req, wr_en;
  logic [4:0]  reg_addr;
  logic [15:0] rd_data, wr_data;
  logic [15:0] mem [32];

  int total = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0, oe_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) mdc = ~mdc;

  assign md_line = md_oe ? md_out : (st_oe ? st_drv : 1'b1);
  assign rd_data = mem[reg_addr];

  mgmt_serial_slave u_mgmt_serial_slave (
    .mdc       (mdc),
    .rst_n     (rst_n),
    .strap_addr(strap),
    .md_in     (md_line),
    .md_out    (md_out),
    .md_oe     (md_oe),
    .reg_addr  (reg_addr),
    .rd_req    (rd_req),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_data   (wr_data)
  );

  always @(posedge mdc) if (wr_en) mem[reg_addr] <= wr_data;

  always @(negedge mdc) begin
    if (wr_en)  wr_cnt++;
    if (rd_req) rd_cnt++;
    if (md_oe)  oe_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit addr_ok(input logic [4:0] a, input logic [2:0] s);
    return (a[4:3] == 2'b00) && (a[2:0] == s);
  endfunction

  task automatic step();
    @(negedge mdc);
    #1;
  endtask

  task automatic send(input logic b);
    step();
    st_oe  = 1'b1;
    st_drv = b;
  endtask

  task automatic frame(input int pre_n, input logic [1:0] op, input logic [4:0] dev,
                       input logic [4:0] ra, input logic [1:0] ta,
                       input logic [15:0] dat, input bit fresh, input string tag);
    bit is_rd, resp;
    int wr0, rd0, oe0;
    logic [15:0] got, exp;
    is_rd = (op == 2'b10);
    resp  = fresh && (pre_n >= 32) && (op == 2'b10 || op == 2'b01) &&
            (is_rd || ta == 2'b10) && addr_ok(dev, strap);
    wr0 = wr_cnt; rd0 = rd_cnt; oe0 = oe_cnt;
    got = '0;
    for (int i = 0; i < pre_n; i++) send(1'b1);
    send(1'b0); send(1'b1);
    send(op[1]); send(op[0]);
    for (int i = 4; i >= 0; i--) send(dev[i]);
    for (int i = 4; i >= 0; i--) send(ra[i]);
    if (is_rd) begin
      exp = mem[ra];
      for (int k = 0; k < 18; k++) begin
        step();
        st_oe = 1'b0;
        if (k == 0) begin
          chk(rd_req == resp, {tag, " R6 rd_req"}, rd_req, resp);
          if (resp) chk(reg_addr == ra, {tag, " R6 reg_addr"}, reg_addr, ra);
          chk(md_oe == 1'b0, {tag, " R7 first turnaround undriven"}, md_oe, 0);
        end else if (k == 1) begin
          chk(md_oe == resp, {tag, " R7 second turnaround oe"}, md_oe, resp);
          if (resp) chk(md_out == 1'b0, {tag, " R7 turnaround zero"}, md_out, 0);
        end else begin
          got[17-k] = md_line;
        end
      end
      step();
      if (resp) chk(got == exp, {tag, " R7 read data"}, got, exp);
      chk(md_oe == 1'b0, {tag, " R10 released"}, md_oe, 0);
    end else begin
      send(ta[1]); send(ta[0]);
      for (int i = 15; i >= 0; i--) send(dat[i]);
      step();
      st_oe = 1'b0;
      chk(wr_en == resp, {tag, " R9 wr_en"}, wr_en, resp);
      if (resp) begin
        chk(reg_addr == ra, {tag, " R9 wr addr"}, reg_addr, ra);
        chk(wr_data == dat, {tag, " R9 wr data"}, wr_data, dat);
      end
    end
    step();
    chk(wr_cnt - wr0 == ((resp && !is_rd) ? 1 : 0), {tag, " R4 write count"}, wr_cnt - wr0, resp && !is_rd);
    chk(rd_cnt - rd0 == ((resp && is_rd) ? 1 : 0), {tag, " R6 read count"}, rd_cnt - rd0, resp && is_rd);
    chk(oe_cnt - oe0 == ((resp && is_rd) ? 17 : 0), {tag, " R7 drive cycles"}, oe_cnt - oe0, (resp && is_rd) ? 17 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge mdc);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [4:0] dev;
    logic [1:0] op;
    seed = $urandom(32'd24681);
    rst_n = 1'b0; st_oe = 1'b0; st_drv = 1'b1; strap = 3'd5;
    for (int i = 0; i < 32; i++) mem[i] = 16'($urandom);
    repeat (3) step();
    chk(md_oe == 1'b0, "R1 reset oe", md_oe, 0);
    chk(rd_req == 1'b0, "R1 reset rd_req", rd_req, 0);
    chk(wr_en == 1'b0, "R1 reset wr_en", wr_en, 0);
    rst_n = 1'b1;
    repeat (4) step();

    frame(32, 2'b01, 5'd5, 5'd3, 2'b10, 16'hA5C3, 1, "R9 basic write");
    frame(32, 2'b10, 5'd5, 5'd3, 2'b00, 16'h0, 1, "R7 basic read");
    chk(mem[3] == 16'hA5C3, "R9 stored", mem[3], 16'hA5C3);

    send(1'b0);
    frame(31, 2'b01, 5'd5, 5'd3, 2'b10, 16'h0F0F, 1, "R2 short preamble");
    frame(32, 2'b10, 5'd5, 5'd3, 2'b00, 16'h0, 1, "R2 readback after short");

    frame(32, 2'b11, 5'd5, 5'd4, 2'b10, 16'h0000, 1, "R3 bad op 11");
    frame(0, 2'b10, 5'd5, 5'd4, 2'b00, 16'h0, 0, "R3 no fresh preamble");
    frame(32, 2'b00, 5'd5, 5'd4, 2'b10, 16'h0000, 1, "R3 bad op 00");
    frame(32, 2'b10, 5'd5, 5'd4, 2'b00, 16'h0, 1, "R3 recovered read");

    frame(32, 2'b01, 5'd5, 5'd6, 2'b00, 16'h0000, 1, "R8 turnaround 00");
    frame(32, 2'b01, 5'd5, 5'd6, 2'b11, 16'h0000, 1, "R8 turnaround 11");

    frame(32, 2'b01, 5'b01101, 5'd7, 2'b10, 16'h1234, 1, "R4 upper bit 3");
    frame(32, 2'b10, 5'b10101, 5'd7, 2'b00, 16'h0, 1, "R4 upper bit 4 read");
    frame(32, 2'b01, 5'd4, 5'd7, 2'b10, 16'h1234, 1, "R4 other strap");

    frame(32, 2'b01, 5'd0, 5'd8, 2'b10, 16'hBEEF, 1, "R5 addr0 nonzero strap");
    frame(32, 2'b10, 5'd0, 5'd8, 2'b00, 16'h0, 1, "R5 addr0 read ignored");
    strap = 3'd0;
    frame(32, 2'b01, 5'd0, 5'd8, 2'b10, 16'hBEEF, 1, "R5 addr0 strap0 write");
    frame(32, 2'b10, 5'd0, 5'd8, 2'b00, 16'h0, 1, "R5 addr0 strap0 read");

    for (int n = 0; n < 80; n++) begin
      if (n % 10 == 0) strap = 3'($urandom);
      dev = ($urandom % 3 == 0) ? 5'($urandom) : {2'b00, strap};
      op  = ($urandom % 2 == 0) ? 2'b10 : 2'b01;
      frame(32 + int'($urandom % 4), op, dev, 5'($urandom), 2'b10, 16'($urandom), 1,
            (op == 2'b10) ? "R10 random read" : "R10 random write");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule